// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Address-Space Tags

This block holds a small set of recently used page mappings and translates a 32-bit virtual address to a physical address in the same cycle it is presented. Pages are 4 KB on both sides, so the low 12 bits pass straight through and only the upper 20 bits are replaced. Every entry is compared in parallel against the requested page number and the current address-space identifier. An entry can be marked global, and a global entry matches under any identifier. Each entry also carries read, write and user-access rights. A hit whose rights do not cover the current access raises a fault flag.

A lookup that finds no usable entry reports a miss. The agent that handles misses, which may be software or a table walker, then writes the mapping through the refill port. The block picks the slot itself and shows it on `fill_slot` before the edge. It reuses a slot that already holds the same mapping. If there is none, it takes the lowest empty slot. When every slot is full, the low bits of a free-running LFSR choose the victim. Two invalidate inputs clear the buffer: one clears every entry, the other clears only the non-global entries of one identifier.

Top module: `tlb_fa`

## Requirements
- R1: A lookup hits when a valid entry's page number equals `lk_vaddr[31:12]` and its identifier matches. On a hit, `lk_paddr` is the entry's frame number in bits 31:12 and `lk_vaddr[11:0]` in bits 11:0.
- R2: On a miss, `lk_hit`, `lk_fault` and `lk_paddr` are all 0. On a hit, `lk_paddr[11:0]` always equals `lk_vaddr[11:0]`.
- R3: On a hit, `lk_fault` is 1 in either of two cases: the access is a write (`lk_write`=1) without write right, or a read (`lk_write`=0) without read right. It is also 1 when the access is from user mode (`lk_user`=1) and the entry lacks user right. Kernel accesses (`lk_user`=0) ignore the user right.
- R4: A non-global entry matches only when its stored identifier equals `lk_asid`. A global entry matches any `lk_asid`.
- R5: A refill with `rf_valid`=1 writes slot `fill_slot` at the next rising edge. A lookup in the same cycle sees the contents from before the refill.
- R6: When a valid entry has the refill's page number and either is global or has identifier `rf_asid`, `fill_slot` points to the lowest such entry.
- R7: Otherwise, if any slot is invalid, `fill_slot` is the lowest invalid slot.
- R8: Otherwise, `fill_slot` is taken from an 8-bit LFSR that advances every cycle and never holds zero, so consecutive victims vary.
- R9: `fl_all` invalidates every entry at the next edge. A refill in the same cycle is still written and is valid afterwards.
- R10: `fl_asid_en` invalidates, at the next edge, only the non-global entries whose identifier equals `fl_asid`. Global entries and entries of other identifiers are kept.
- R11: If several valid entries match a lookup, the lowest-numbered one supplies the frame number and the rights.
- R12: After reset all entries are invalid, every lookup misses, and `fill_slot` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_user | input | 1 | 1 = user-mode access, 0 = kernel |
| lk_hit | output | 1 | A valid matching entry exists |
| lk_paddr | output | 32 | Translated physical address (0 on miss) |
| lk_fault | output | 1 | Hit, but the access is not permitted |
| rf_valid | input | 1 | Write a mapping at the next edge |
| rf_vpn | input | 20 | Virtual page number of the mapping |
| rf_asid | input | 8 | Identifier of the mapping |
| rf_pfn | input | 20 | Physical frame number |
| rf_global | input | 1 | Mapping matches under any identifier |
| rf_perm_r | input | 1 | Read right |
| rf_perm_w | input | 1 | Write right |
| rf_perm_u | input | 1 | User-mode right |
| fill_slot | output | 4 | Slot the next refill will write |
| fl_all | input | 1 | Invalidate every entry |
| fl_asid_en | input | 1 | Invalidate non-global entries of `fl_asid` |
| fl_asid | input | 8 | Identifier to invalidate |

## Verification
The bench builds the block with its default parameters: 16 entries, 8-bit identifiers, 4 KB pages and an 8-bit LFSR. With 16 slots, a pool of about two dozen page numbers across three identifiers fills the buffer quickly. That forces the random-victim path, overwrites of existing mappings and overlapping global and per-identifier entries within a few hundred operations. An 8-bit identifier lets directed cases show a global entry hitting under identifiers far from the one it was loaded with.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef struct packed {
    logic rd;
    logic wr;
    logic usr;
  } perm_t;

  // Access check: read or write right by direction, user right only in user mode
  function automatic logic perm_fault(perm_t p, logic is_write, logic is_user);
    logic dir_bad;
    dir_bad = is_write ? !p.wr : !p.rd;
    return dir_bad || (is_user && !p.usr);
  endfunction

  function automatic logic tag_match(logic ent_valid, logic ent_glob,
                                     logic [31:0] ent_vpn, logic [31:0] req_vpn,
                                     logic [15:0] ent_asid, logic [15:0] req_asid);
    return ent_valid && (ent_vpn == req_vpn) && (ent_glob || ent_asid == req_asid);
  endfunction

endpackage

// File: rtl/tlb_first_one.sv
module tlb_first_one #(
  parameter int N = 16
) (
  input  logic [N-1:0]         vec,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  always_ff @(posedge clk) begin
    if (!rst_n)        state <= W'(1);
    else if (state[0]) state <= (state >> 1) ^ TAPS;
    else               state <= state >> 1;
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int ENTRIES   = 16,
  parameter int ASID_W    = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [VA_W-1:0]           lk_vaddr,
  input  logic [ASID_W-1:0]         lk_asid,
  input  logic                      lk_write,
  input  logic                      lk_user,
  output logic                      lk_hit,
  output logic [PA_W-1:0]           lk_paddr,
  output logic                      lk_fault,
  input  logic                      rf_valid,
  input  logic [VA_W-PAGE_BITS-1:0] rf_vpn,
  input  logic [ASID_W-1:0]         rf_asid,
  input  logic [PA_W-PAGE_BITS-1:0] rf_pfn,
  input  logic                      rf_global,
  input  logic                      rf_perm_r,
  input  logic                      rf_perm_w,
  input  logic                      rf_perm_u,
  output logic [$clog2(ENTRIES)-1:0] fill_slot,
  input  logic                      fl_all,
  input  logic                      fl_asid_en,
  input  logic [ASID_W-1:0]         fl_asid
);
  import tlb_pkg::*;

  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PFN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = $clog2(ENTRIES);

  // Entry storage
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] glob_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  perm_t              perm_q [ENTRIES];

  // Named internal events, observed by the checker
  logic [ENTRIES-1:0] lk_match, rf_match, kill;
  logic               lk_any, rf_match_any, free_any;
  logic [IDX_W-1:0]   lk_idx, rf_idx, free_idx;
  logic               fill_from_match, fill_from_free, fill_from_rand;
  logic [LFSR_W-1:0]  lfsr_q;

  logic [VPN_W-1:0] lk_vpn;
  assign lk_vpn = lk_vaddr[VA_W-1:PAGE_BITS];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_match[i] = tag_match(valid_q[i], glob_q[i], 32'(vpn_q[i]), 32'(lk_vpn),
                                   16'(asid_q[i]), 16'(lk_asid));
    assign rf_match[i] = tag_match(valid_q[i], glob_q[i], 32'(vpn_q[i]), 32'(rf_vpn),
                                   16'(asid_q[i]), 16'(rf_asid));
    assign kill[i]     = fl_all || (fl_asid_en && !glob_q[i] && asid_q[i] == fl_asid);
  end

  tlb_first_one #(.N(ENTRIES)) u_lk_pick   (.vec(lk_match), .any(lk_any),       .idx(lk_idx));
  tlb_first_one #(.N(ENTRIES)) u_rf_pick   (.vec(rf_match), .any(rf_match_any), .idx(rf_idx));
  tlb_first_one #(.N(ENTRIES)) u_free_pick (.vec(~valid_q), .any(free_any),     .idx(free_idx));

  tlb_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS)) u_lfsr (.clk(clk), .rst_n(rst_n), .state(lfsr_q));

  // Victim selection: existing mapping, then lowest free slot, then pseudo-random
  assign fill_from_match = rf_match_any;
  assign fill_from_free  = !rf_match_any && free_any;
  assign fill_from_rand  = !rf_match_any && !free_any;

  always_comb begin
    if (fill_from_match)     fill_slot = rf_idx;
    else if (fill_from_free) fill_slot = free_idx;
    else                     fill_slot = lfsr_q[IDX_W-1:0];
  end

  // Translation result
  always_comb begin
    lk_hit   = lk_any;
    lk_paddr = '0;
    lk_fault = 1'b0;
    if (lk_any) begin
      lk_paddr = {pfn_q[lk_idx], lk_vaddr[PAGE_BITS-1:0]};
      lk_fault = perm_fault(perm_q[lk_idx], lk_write, lk_user);
    end
  end

  // Entry update: invalidation first, a refill of the same slot wins
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic wr_here;
    assign wr_here = rf_valid && (fill_slot == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
      end else if (wr_here) begin
        valid_q[i] <= 1'b1;
      end else if (kill[i]) begin
        valid_q[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        glob_q[i] <= 1'b0;
        vpn_q[i]  <= '0;
        asid_q[i] <= '0;
        pfn_q[i]  <= '0;
        perm_q[i] <= '0;
      end else if (wr_here) begin
        glob_q[i] <= rf_global;
        vpn_q[i]  <= rf_vpn;
        asid_q[i] <= rf_asid;
        pfn_q[i]  <= rf_pfn;
        perm_q[i] <= '{rd: rf_perm_r, wr: rf_perm_w, usr: rf_perm_u};
      end
    end
  end

endmodule

// File: rtl/tlb_fa_checker.sv
module tlb_fa_checker #(
  parameter int ENTRIES   = 16,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int LFSR_W    = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [VA_W-1:0]            lk_vaddr,
  input logic                       lk_hit,
  input logic [PA_W-1:0]            lk_paddr,
  input logic                       lk_fault,
  input logic                       rf_valid,
  input logic                       fl_all,
  input logic [$clog2(ENTRIES)-1:0] fill_slot,
  input logic [ENTRIES-1:0]         valid_q,
  input logic                       rf_match_any,
  input logic [LFSR_W-1:0]          lfsr_q
);

  p_fault_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);

  p_offset_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]);

  p_miss_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == '0 && !lk_fault));

  p_refill_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid |=> valid_q[$past(fill_slot)]);

  p_free_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rf_match_any && !(&valid_q)) |-> !valid_q[fill_slot]);

  p_lfsr_alive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_all && !rf_valid) |=> valid_q == '0);

  p_flush_keeps_refill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_all && rf_valid) |=> $countones(valid_q) == 1);

endmodule

bind tlb_fa tlb_fa_checker #(
  .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .LFSR_W(LFSR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
  .lk_fault(lk_fault), .rf_valid(rf_valid), .fl_all(fl_all), .fill_slot(fill_slot),
  .valid_q(valid_q), .rf_match_any(rf_match_any), .lfsr_q(lfsr_q)
);

// File: tb/tlb_fa_bench.sv
module tlb_fa_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_write = 1'b0, lk_user = 1'b0;
  logic        lk_hit, lk_fault;
  logic [31:0] lk_paddr;
  logic        rf_valid = 1'b0;
  logic [19:0] rf_vpn = '0, rf_pfn = '0;
  logic [7:0]  rf_asid = '0;
  logic        rf_global = 1'b0, rf_perm_r = 1'b0, rf_perm_w = 1'b0, rf_perm_u = 1'b0;
  logic [3:0]  fill_slot;
  logic        fl_all = 1'b0, fl_asid_en = 1'b0;
  logic [7:0]  fl_asid = '0;

  always #4 clk = ~clk;

  tlb_fa u_tlb_fa (.*);

  // Bench model of the entries
  bit          m_v [N];
  bit          m_g [N];
  logic [19:0] m_vpn [N];
  logic [7:0]  m_asid [N];
  logic [19:0] m_pfn [N];
  bit          m_r [N], m_w [N], m_u [N];

  int checks = 0, fails = 0;
  bit done = 0;
  bit seen_slot [N];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit mdl_match(int i, logic [19:0] vpn, logic [7:0] a);
    return m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asid[i] == a);
  endfunction

  // Expected slot for the match and free cases; -1 means pseudo-random
  function automatic int exp_slot(logic [19:0] vpn, logic [7:0] a);
    for (int i = 0; i < N; i++) if (mdl_match(i, vpn, a)) return i;
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    return -1;
  endfunction

  task automatic lookup(input logic [31:0] va, input logic [7:0] a, input bit wr, input bit us, input string req);
    bit e_hit = 0, e_fault = 0;
    logic [31:0] e_pa = '0;
    @(negedge clk);
    lk_vaddr = va; lk_asid = a; lk_write = wr; lk_user = us;
    #1;
    for (int i = 0; i < N; i++) begin
      if (!e_hit && mdl_match(i, va[31:12], a)) begin
        e_hit = 1;
        e_pa = {m_pfn[i], va[11:0]};
        e_fault = (wr ? !m_w[i] : !m_r[i]) || (us && !m_u[i]);
      end
    end
    check(lk_hit == e_hit, {req, " hit"}, 64'(lk_hit), 64'(e_hit));
    check(lk_paddr == e_pa, {req, " paddr"}, 64'(lk_paddr), 64'(e_pa));
    check(lk_fault == e_fault, {req, " fault"}, 64'(lk_fault), 64'(e_fault));
  endtask

  task automatic refill(input logic [19:0] vpn, input logic [7:0] a, input logic [19:0] pfn,
                        input bit g, input bit r, input bit w, input bit u, input string req);
    int es, s;
    @(negedge clk);
    rf_valid = 1; rf_vpn = vpn; rf_asid = a; rf_pfn = pfn; rf_global = g;
    rf_perm_r = r; rf_perm_w = w; rf_perm_u = u;
    #1;
    es = exp_slot(vpn, a);
    s = int'(fill_slot);
    if (es >= 0) check(s == es, {req, " fill_slot"}, 64'(s), 64'(es));
    else seen_slot[s] = 1;
    @(posedge clk);
    #1;
    rf_valid = 0;
    m_v[s] = 1; m_g[s] = g; m_vpn[s] = vpn; m_asid[s] = a; m_pfn[s] = pfn;
    m_r[s] = r; m_w[s] = w; m_u[s] = u;
  endtask

  task automatic flush_asid(input logic [7:0] a);
    @(negedge clk);
    fl_asid_en = 1; fl_asid = a;
    @(posedge clk);
    #1;
    fl_asid_en = 0;
    for (int i = 0; i < N; i++) if (!m_g[i] && m_asid[i] == a) m_v[i] = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    int distinct;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_g[i] = 0; seen_slot[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R12: empty after reset
    lookup(32'h1234_5678, 8'd1, 0, 0, "R12");
    check(fill_slot == 4'd0, "R12 fill_slot", 64'(fill_slot), 64'd0);

    // R1/R7: first refill takes slot 0, translates with offset kept
    refill(20'h12345, 8'd1, 20'hABCDE, 0, 1, 1, 0, "R7");
    lookup(32'h1234_5678, 8'd1, 0, 0, "R1");
    check(lk_paddr == 32'hABCD_E678, "R1 literal paddr", 64'(lk_paddr), 64'hABCDE678);
    // R4: other identifier misses
    lookup(32'h1234_5678, 8'd2, 0, 0, "R4");
    check(lk_hit == 1'b0, "R4 other asid", 64'(lk_hit), 64'd0);
    // R3: user mode without user right faults; kernel write allowed
    lookup(32'h1234_5000, 8'd1, 1, 0, "R3 kernel write");
    lookup(32'h1234_5000, 8'd1, 0, 1, "R3 user read");
    check(lk_fault == 1'b1, "R3 user fault", 64'(lk_fault), 64'd1);

    // R4: global read-only user entry seen from any identifier
    refill(20'h00042, 8'd5, 20'h00777, 1, 1, 0, 1, "R7 second");
    lookup(32'h0004_2ABC, 8'd200, 0, 1, "R4 global");
    check(lk_hit == 1'b1, "R4 global hit", 64'(lk_hit), 64'd1);
    lookup(32'h0004_2ABC, 8'd9, 1, 0, "R3 write no right");

    // R6: same mapping reuses its slot
    refill(20'h12345, 8'd1, 20'h0F0F0, 0, 1, 1, 1, "R6");
    lookup(32'h1234_5001, 8'd1, 0, 1, "R6 new pfn");

    // R5: refill and lookup in one cycle, old contents first
    @(negedge clk);
    rf_valid = 1; rf_vpn = 20'h55555; rf_asid = 8'd1; rf_pfn = 20'h11111; rf_global = 0;
    rf_perm_r = 1; rf_perm_w = 1; rf_perm_u = 1;
    lk_vaddr = 32'h5555_5010; lk_asid = 8'd1; lk_write = 0; lk_user = 0;
    #1;
    check(lk_hit == 1'b0, "R5 same-cycle old", 64'(lk_hit), 64'd0);
    m_v[fill_slot] = 1; m_g[fill_slot] = 0; m_vpn[fill_slot] = 20'h55555; m_asid[fill_slot] = 8'd1;
    m_pfn[fill_slot] = 20'h11111; m_r[fill_slot] = 1; m_w[fill_slot] = 1; m_u[fill_slot] = 1;
    @(posedge clk);
    #1 rf_valid = 0;
    lookup(32'h5555_5010, 8'd1, 0, 0, "R5 after edge");
    check(lk_paddr == 32'h1111_1010, "R5 literal", 64'(lk_paddr), 64'h11111010);

    // R10: identifier flush keeps global entry
    flush_asid(8'd1);
    lookup(32'h5555_5010, 8'd1, 0, 0, "R10 gone");
    lookup(32'h0004_2000, 8'd1, 0, 0, "R10 global kept");
    check(lk_hit == 1'b1, "R10 global hit", 64'(lk_hit), 64'd1);

    // R9: full flush with simultaneous refill
    @(negedge clk);
    fl_all = 1; rf_valid = 1; rf_vpn = 20'h00777; rf_asid = 8'd3; rf_pfn = 20'h22222;
    rf_global = 0; rf_perm_r = 1; rf_perm_w = 0; rf_perm_u = 0;
    #1;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_v[fill_slot] = 1; m_g[fill_slot] = 0; m_vpn[fill_slot] = 20'h00777; m_asid[fill_slot] = 8'd3;
    m_pfn[fill_slot] = 20'h22222; m_r[fill_slot] = 1; m_w[fill_slot] = 0; m_u[fill_slot] = 0;
    @(posedge clk);
    #1 fl_all = 0; rf_valid = 0;
    lookup(32'h0004_2000, 8'd5, 0, 0, "R9 flushed");
    lookup(32'h0077_7000, 8'd3, 0, 0, "R9 refill kept");
    check(lk_hit == 1'b1, "R9 refill hit", 64'(lk_hit), 64'd1);

    // R11: overlapping entries, lowest slot wins
    @(negedge clk); fl_all = 1; @(posedge clk); #1 fl_all = 0;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    refill(20'h00007, 8'd2, 20'h0AAAA, 0, 1, 1, 1, "R11 first");
    refill(20'h00007, 8'd1, 20'h0BBBB, 1, 1, 0, 0, "R11 second");
    lookup(32'h0000_7004, 8'd2, 1, 1, "R11");
    check(lk_paddr == 32'h0AAA_A004, "R11 literal", 64'(lk_paddr), 64'h0AAAA004);

    // R8: fill everything, then replace with new mappings
    for (int k = 0; k < 40; k++)
      refill(20'h30000 + 20'(k), 8'd4, 20'h40000 + 20'(k), 0, 1, 1, 1, "R8 fill");
    distinct = 0;
    for (int i = 0; i < N; i++) if (seen_slot[i]) distinct++;
    check(distinct >= 4, "R8 victim spread", 64'(distinct), 64'd4);

    // Random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      logic [19:0] vpn;
      logic [7:0] a;
      op  = int'($urandom_range(0, 9));
      vpn = 20'($urandom_range(0, 23));
      a   = 8'($urandom_range(1, 3));
      if (op < 4)
        refill(vpn, a, 20'($urandom), ($urandom_range(0, 7) == 0), 1'($urandom), 1'($urandom), 1'($urandom), "R6/R7/R8 random");
      else if (op < 9)
        lookup({vpn, 12'($urandom)}, a, 1'($urandom), 1'($urandom), "R1/R3/R4/R11 random");
      else
        flush_asid(a);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule